// File: doc/BRIEF.md
# Half-Duplex Two-Wire Command Slave

This block is the slave end of a two-wire link to a host controller. Both wires are open drain. One wire is a data line that carries asynchronous 8N1 bytes in both directions, one direction at a time. The other wire is an enable strobe that frames each transaction. The host pulls the strobe low, sends a command byte and any parameter bytes, and then releases the strobe. The slave then pulls the strobe low itself, returns a status byte and any data bytes, and releases the strobe when its last stop bit has gone out.

Received bytes go to a command executor one at a time over a valid/take handshake. A flag marks the first byte of a transaction as the command. The executor returns reply bytes through a ready/valid push into a small transmit queue, and marks the end of the reply with a done pulse. The pads appear as input samples and drive-low enables. The block never drives either line high.

The controller is built around six named states:
- `ST_IDLE`
- `ST_RX_CMD` (wait for the command byte)
- `ST_RX_PARAM` (pass or discard parameter bytes)
- `ST_TX_STATUS` (queue the status byte)
- `ST_TX_DATA` (accept reply bytes)
- `ST_FINAL` (drain, then release)

The transitions are:
- strobe fall: IDLE to RX_CMD.
- command byte: RX_CMD to RX_PARAM.
- strobe rise: RX_CMD or RX_PARAM to TX_STATUS.
- always: TX_STATUS to TX_DATA.
- done pulse: TX_DATA to FINAL.
- queue empty and shifter idle: FINAL to IDLE.

Any unused encoding returns to IDLE.

Top module: `hostlink_slave`

## Requirements
- R1: After reset, neither line is pulled low and no byte is offered to the executor.
- R2: A falling strobe in idle opens a transaction. The first received byte is offered with `cmd_first`=1. If its bit 7 is set, it is offered as 0x7F instead.
- R3: Later bytes are offered in arrival order with `cmd_first`=0. Each offered byte stays valid and stable until `cmd_take`.
- R4: A command code of NUM_CMDS (8) or more is still offered, but it sets status bit 0. All later bytes of that transaction are discarded.
- R5: Status bit 1 (missing parameter) is set when a command arrives. It is cleared only when the executor takes a parameter byte.
- R6: If a byte completes while the previous byte is still untaken, the new byte is dropped and status bit 2 (overrun) is set. The overrun flag clears once the status byte is queued and again on each falling strobe.
- R7: A `term_par_err` pulse during a transaction sets status bit 3. Status bits 7:4 are always zero.
- R8: On a rising strobe, the slave pulls the strobe low and sends the status byte, then the reply bytes in push order. Each byte goes out as one low start bit, 8 data bits LSB first (low means 0), and one released stop bit, each bit lasting CLK_HZ/BAUD cycles.
- R9: After `rsp_done`, the slave releases the strobe only once the queue is empty and the last stop bit has finished. It then returns to idle, and a new transaction is accepted.
- R10: The data line is never pulled by the slave while it is receiving. Received bits are sampled 1.5 bit times after the start edge and then once per bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dq_pad_in | input | 1 | Sampled level of the data line |
| dq_drive_low | output | 1 | Pull the data line low |
| we_pad_in | input | 1 | Sampled level of the strobe line |
| we_drive_low | output | 1 | Pull the strobe line low |
| cmd_valid | output | 1 | A received byte is offered |
| cmd_first | output | 1 | The offered byte is the command byte |
| cmd_byte | output | 8 | Offered byte |
| cmd_take | input | 1 | Executor consumes the offered byte |
| term_par_err | input | 1 | Pulse: terminal parity error seen |
| rsp_ready | output | 1 | Reply byte can be pushed |
| rsp_valid | input | 1 | Reply byte push |
| rsp_data | input | 8 | Reply byte |
| rsp_done | input | 1 | Reply complete |

## Verification
A corrupted controller state shows at the ports as a misplaced strobe hold. The slave either never pulls the strobe after the host lets go, or it releases the strobe while a frame is still on the data line. Both are visible within one bit time of the faulty transition. A wrong flag shows up in the very next status byte, one frame after the strobe rise. A broken receive path shows up as a changed or missing byte at the executor handshake within one frame of the bad bit. The bench compares every offered byte and every returned byte against values it computes itself.

// File: rtl/hls_pkg.sv
package hls_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_RX_CMD    = 3'd1,
        ST_RX_PARAM  = 3'd2,
        ST_TX_STATUS = 3'd3,
        ST_TX_DATA   = 3'd4,
        ST_FINAL     = 3'd5
    } hls_state_e;

    localparam int STAT_INVALID = 0;
    localparam int STAT_NOPARAM = 1;
    localparam int STAT_OVERRUN = 2;
    localparam int STAT_PARITY  = 3;

    localparam logic [7:0] CMD_CLAMP = 8'h7F;

endpackage

// File: rtl/hls_sync.sv
module hls_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], din};
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/hls_uart_rx.sv
module hls_uart_rx #(
    parameter int BIT_TICKS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       line,
    output logic       byte_valid,
    output logic [7:0] byte_data
);
    localparam int CW = $clog2(BIT_TICKS + BIT_TICKS / 2 + 1);
    localparam logic [CW-1:0] FIRST_WAIT = CW'(BIT_TICKS + BIT_TICKS / 2 - 1);
    localparam logic [CW-1:0] NEXT_WAIT  = CW'(BIT_TICKS - 1);

    logic          active_q;
    logic [CW-1:0] wait_q;
    logic [3:0]    bitn_q;
    logic [7:0]    shift_q;
    logic          valid_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            wait_q   <= '0;
            bitn_q   <= '0;
            shift_q  <= '0;
            valid_q  <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (!en) begin
                active_q <= 1'b0;
            end else if (!active_q) begin
                if (!line) begin
                    active_q <= 1'b1;
                    wait_q   <= FIRST_WAIT;
                    bitn_q   <= '0;
                end
            end else if (wait_q != '0) begin
                wait_q <= wait_q - 1'b1;
            end else if (bitn_q < 4'd8) begin
                shift_q <= {line, shift_q[7:1]};
                bitn_q  <= bitn_q + 1'b1;
                wait_q  <= NEXT_WAIT;
            end else begin
                active_q <= 1'b0;
                valid_q  <= line;
            end
        end
    end

    assign byte_valid = valid_q;
    assign byte_data  = shift_q;

    // R10: a byte is only delivered while the receiver is enabled
    p_rx_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |-> $past(en));
endmodule

// File: rtl/hls_uart_tx.sv
module hls_uart_tx #(
    parameter int BIT_TICKS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] data,
    output logic       busy,
    output logic       line_low
);
    localparam int CW = $clog2(BIT_TICKS + 1);
    localparam logic [CW-1:0] BIT_WAIT = CW'(BIT_TICKS - 1);

    logic [9:0]    frame_q;
    logic [3:0]    left_q;
    logic [CW-1:0] wait_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_q <= '1;
            left_q  <= '0;
            wait_q  <= '0;
        end else if (load && left_q == 4'd0) begin
            frame_q <= {1'b1, data, 1'b0};
            left_q  <= 4'd10;
            wait_q  <= BIT_WAIT;
        end else if (left_q != 4'd0) begin
            if (wait_q != '0) begin
                wait_q <= wait_q - 1'b1;
            end else begin
                frame_q <= {1'b1, frame_q[9:1]};
                left_q  <= left_q - 1'b1;
                wait_q  <= BIT_WAIT;
            end
        end
    end

    assign busy     = (left_q != 4'd0);
    assign line_low = busy && !frame_q[0];

    // R8: a frame always opens with a low start bit
    p_start_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> line_low);
endmodule

// File: rtl/hls_txq.sv
module hls_txq #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [AW:0]   CAP  = (AW + 1)'(DEPTH);

    logic [W-1:0]  mem_q [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [AW:0]   cnt_q;
    logic          do_push, do_pop;

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CAP);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem_q[rp_q];

    always_ff @(posedge clk) begin
        if (do_push) mem_q[wp_q] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else if (clr) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wp_q <= (wp_q == LAST) ? '0 : wp_q + 1'b1;
            if (do_pop)  rp_q <= (rp_q == LAST) ? '0 : rp_q + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // R8: reply queue occupancy never exceeds its capacity
    p_count_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CAP);
endmodule

// File: rtl/hostlink_slave.sv
module hostlink_slave
    import hls_pkg::*;
#(
    parameter int CLK_HZ    = 96_000_000,
    parameter int BAUD      = 9600,
    parameter int NUM_CMDS  = 8,
    parameter int TXQ_DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dq_pad_in,
    output logic       dq_drive_low,
    input  logic       we_pad_in,
    output logic       we_drive_low,
    output logic       cmd_valid,
    output logic       cmd_first,
    output logic [7:0] cmd_byte,
    input  logic       cmd_take,
    input  logic       term_par_err,
    output logic       rsp_ready,
    input  logic       rsp_valid,
    input  logic [7:0] rsp_data,
    input  logic       rsp_done
);
    localparam int BIT_TICKS = CLK_HZ / BAUD;
    localparam logic [8:0] NCMD = 9'(NUM_CMDS);

    hls_state_e state_q, state_d;

    logic       we_s, dq_s, we_prev_q, we_fall, we_rise;
    logic       rx_en, rx_valid;
    logic [7:0] rx_data, rx_cmd;
    logic       tx_busy, tx_low, tx_load;
    logic       q_clr, q_push, q_empty, q_full;
    logic [7:0] q_din, q_dout, status;
    logic       pend_q, first_q, inv_q, noparam_q, ovr_q, par_q, we_low_q;
    logic [7:0] byte_q;

    hls_sync #(.STAGES(2), .RST_VAL(1'b1)) u_we_sync (
        .clk(clk), .rst_n(rst_n), .din(we_pad_in), .dout(we_s));
    hls_sync #(.STAGES(2), .RST_VAL(1'b1)) u_dq_sync (
        .clk(clk), .rst_n(rst_n), .din(dq_pad_in), .dout(dq_s));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) we_prev_q <= 1'b1;
        else        we_prev_q <= we_s;
    end
    assign we_fall = we_prev_q && !we_s;
    assign we_rise = !we_prev_q && we_s;

    assign rx_en = (state_q == ST_RX_CMD) || (state_q == ST_RX_PARAM);

    hls_uart_rx #(.BIT_TICKS(BIT_TICKS)) u_rx (
        .clk(clk), .rst_n(rst_n), .en(rx_en), .line(dq_s),
        .byte_valid(rx_valid), .byte_data(rx_data));

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (we_fall) state_d = ST_RX_CMD;
            ST_RX_CMD: begin
                if (we_rise)       state_d = ST_TX_STATUS;
                else if (rx_valid) state_d = ST_RX_PARAM;
            end
            ST_RX_PARAM:  if (we_rise) state_d = ST_TX_STATUS;
            ST_TX_STATUS: state_d = ST_TX_DATA;
            ST_TX_DATA:   if (rsp_done) state_d = ST_FINAL;
            ST_FINAL:     if (q_empty && !tx_busy) state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) we_low_q <= 1'b0;
        else        we_low_q <= (state_d == ST_TX_STATUS) || (state_d == ST_TX_DATA) ||
                                (state_d == ST_FINAL);
    end

    assign we_drive_low = we_low_q;
    assign dq_drive_low = tx_low;
    assign cmd_valid    = pend_q;
    assign cmd_first    = first_q;
    assign cmd_byte     = byte_q;
    assign rsp_ready    = (state_q == ST_TX_DATA) && !q_full;

    // ---------------- receive-side flags ----------------
    assign rx_cmd = rx_data[7] ? CMD_CLAMP : rx_data;

    always_comb begin
        status = 8'h00;
        status[STAT_INVALID] = inv_q;
        status[STAT_NOPARAM] = noparam_q;
        status[STAT_OVERRUN] = ovr_q;
        status[STAT_PARITY]  = par_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q    <= 1'b0;
            first_q   <= 1'b0;
            byte_q    <= '0;
            inv_q     <= 1'b0;
            noparam_q <= 1'b0;
            ovr_q     <= 1'b0;
            par_q     <= 1'b0;
        end else if (state_q == ST_IDLE && we_fall) begin
            pend_q    <= 1'b0;
            inv_q     <= 1'b0;
            noparam_q <= 1'b0;
            ovr_q     <= 1'b0;
            par_q     <= 1'b0;
        end else begin
            logic pend_n;
            pend_n = pend_q;
            if (cmd_take && pend_q) begin
                pend_n = 1'b0;
                if (!first_q) noparam_q <= 1'b0;
            end
            if (term_par_err && state_q != ST_IDLE) par_q <= 1'b1;
            if (rx_valid && state_q == ST_RX_CMD && !we_rise) begin
                inv_q     <= ({1'b0, rx_cmd} >= NCMD);
                noparam_q <= 1'b1;
                par_q     <= term_par_err;
                if (pend_n) ovr_q <= 1'b1;
                else begin
                    pend_n  = 1'b1;
                    first_q <= 1'b1;
                    byte_q  <= rx_cmd;
                end
            end else if (rx_valid && state_q == ST_RX_PARAM && !we_rise && !inv_q) begin
                if (pend_n) ovr_q <= 1'b1;
                else begin
                    pend_n  = 1'b1;
                    first_q <= 1'b0;
                    byte_q  <= rx_data;
                end
            end
            if (state_q == ST_TX_STATUS) ovr_q <= 1'b0;
            pend_q <= pend_n;
        end
    end

    // ---------------- transmit path ----------------
    assign q_clr   = (state_q == ST_IDLE) && we_fall;
    assign q_push  = (state_q == ST_TX_STATUS) || (rsp_valid && rsp_ready);
    assign q_din   = (state_q == ST_TX_STATUS) ? status : rsp_data;
    assign tx_load = !tx_busy && !q_empty &&
                     (state_q == ST_TX_DATA || state_q == ST_FINAL);

    hls_txq #(.W(8), .DEPTH(TXQ_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .clr(q_clr), .push(q_push), .din(q_din),
        .pop(tx_load), .dout(q_dout), .empty(q_empty), .full(q_full));

    hls_uart_tx #(.BIT_TICKS(BIT_TICKS)) u_tx (
        .clk(clk), .rst_n(rst_n), .load(tx_load), .data(q_dout),
        .busy(tx_busy), .line_low(tx_low));

    // ---------------- assertions ----------------
    // R8: data line is only pulled while the slave holds the strobe
    p_dq_under_we_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dq_drive_low |-> we_drive_low);
    // R2: the command byte never carries bit 7
    p_cmd_clamped_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_first) |-> !cmd_byte[7]);
    // R3: an offered byte holds until taken
    p_cmd_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_take && state_q != ST_IDLE) |=>
        (cmd_valid && $stable(cmd_byte) && $stable(cmd_first)));
    // R4: no parameter is offered after an invalid command
    p_no_param_invalid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_first) |-> !inv_q);
    // R9: strobe released only with an empty queue and idle shifter
    p_clean_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(we_drive_low) |-> (q_empty && !tx_busy));
    // R10: no drive of the data line while receiving
    p_rx_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_en |-> !dq_drive_low);
endmodule

// File: tb/sim_hostlink_slave.sv
module sim_hostlink_slave;
    localparam int BT = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic host_dq_low = 1'b0, host_we_low = 1'b0;
    logic dq_drive_low, we_drive_low, cmd_valid, cmd_first, rsp_ready;
    logic [7:0] cmd_byte;
    logic cmd_take = 1'b0, term_par_err = 1'b0, rsp_valid = 1'b0, rsp_done = 1'b0;
    logic [7:0] rsp_data = 8'h00;
    wire dq_line = ~(host_dq_low | dq_drive_low);
    wire we_line = ~(host_we_low | we_drive_low);

    hostlink_slave #(.CLK_HZ(1_600_000), .BAUD(100_000), .NUM_CMDS(8), .TXQ_DEPTH(4)) u0 (
        .clk(clk), .rst_n(rst_n), .dq_pad_in(dq_line), .dq_drive_low(dq_drive_low),
        .we_pad_in(we_line), .we_drive_low(we_drive_low), .cmd_valid(cmd_valid),
        .cmd_first(cmd_first), .cmd_byte(cmd_byte), .cmd_take(cmd_take),
        .term_par_err(term_par_err), .rsp_ready(rsp_ready), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .rsp_done(rsp_done));

    int tests = 0, fails = 0;
    bit finished = 0;
    bit stall = 0;
    logic [7:0] seen_b [16];
    logic       seen_f [16];
    int         seen_n = 0;
    logic [7:0] got_b [16];
    int         got_n = 0;

    task automatic check(input string req, input int act, input int exp, input string what);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] clamp(input logic [7:0] c);
        return c[7] ? 8'h7F : c;
    endfunction

    function automatic logic [7:0] exp_status(input bit has_cmd, input logic [7:0] c,
                                              input int np, input bit ovr, input bit par);
        logic [7:0] s;
        s = 8'h00;
        if (has_cmd) begin
            s[0] = (clamp(c) >= 8'd8);
            s[1] = s[0] ? 1'b1 : (np == 0);
            s[2] = ovr;
            s[3] = par;
        end
        return s;
    endfunction

    // executor: take offered bytes unless stalled
    initial begin
        forever begin
            @(negedge clk);
            if (cmd_take) cmd_take = 1'b0;
            else if (cmd_valid && !stall && seen_n < 16) begin
                seen_b[seen_n] = cmd_byte;
                seen_f[seen_n] = cmd_first;
                seen_n++;
                cmd_take = 1'b1;
            end
        end
    end

    task automatic send_byte(input logic [7:0] b);
        host_dq_low = 1'b1;
        repeat (BT) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            host_dq_low = ~b[i];
            repeat (BT) @(negedge clk);
        end
        host_dq_low = 1'b0;
        repeat (BT + 8) @(negedge clk);
    endtask

    task automatic recv_all();
        int guard;
        logic [7:0] b;
        guard = 0;
        while (!we_drive_low && guard < 200) begin @(negedge clk); guard++; end
        while (we_drive_low && guard < 20000) begin
            @(negedge clk); guard++;
            if (dq_drive_low) begin
                repeat (BT + BT / 2) @(negedge clk);
                for (int i = 0; i < 8; i++) begin
                    b[i] = ~dq_drive_low;
                    if (i < 7) repeat (BT) @(negedge clk);
                end
                repeat (BT) @(negedge clk);
                check("R8", {31'b0, ~dq_drive_low}, 1, "stop bit released");
                if (got_n < 16) got_b[got_n] = b;
                got_n++;
            end
        end
    endtask

    task automatic respond(input int nd, input logic [7:0] d [4]);
        for (int i = 0; i < nd; i++) begin
            do @(negedge clk); while (!rsp_ready);
            rsp_valid = 1'b1; rsp_data = d[i];
            @(negedge clk);
            rsp_valid = 1'b0;
        end
        do @(negedge clk); while (!rsp_ready);
        rsp_done = 1'b1;
        @(negedge clk);
        rsp_done = 1'b0;
    endtask

    task automatic run_txn(input bit has_cmd, input logic [7:0] c, input int np,
                           input logic [7:0] p [4], input int nd, input logic [7:0] d [4],
                           input bit ovr_case, input bit par_case);
        logic [7:0] st;
        int exp_n;
        seen_n = 0; got_n = 0;
        host_we_low = 1'b1;
        repeat (6) @(negedge clk);
        if (has_cmd) begin
            send_byte(c);
            if (ovr_case) stall = 1'b1;
            for (int i = 0; i < np; i++) send_byte(p[i]);
        end
        if (par_case) begin term_par_err = 1'b1; @(negedge clk); term_par_err = 1'b0; end
        stall = 1'b0;
        repeat (8) @(negedge clk);
        check("R10", {30'b0, dq_drive_low, we_drive_low}, 0, "slave quiet while host owns link");
        host_we_low = 1'b0;
        fork
            recv_all();
            respond(nd, d);
        join
        // offered bytes
        exp_n = 0;
        if (has_cmd) begin
            exp_n = 1;
            if (clamp(c) < 8'd8) exp_n = ovr_case ? 1 + (np > 0 ? 1 : 0) : 1 + np;
        end
        check("R3", seen_n, exp_n, "offered byte count");
        if (has_cmd && seen_n > 0) begin
            check("R2", seen_b[0], clamp(c), "command byte");
            check("R2", {31'b0, seen_f[0]}, 1, "command first flag");
        end
        for (int i = 1; i < seen_n && i < exp_n; i++) begin
            check("R3", seen_b[i], p[i-1], "parameter byte");
            check("R3", {31'b0, seen_f[i]}, 0, "parameter first flag");
        end
        st = exp_status(has_cmd, c, np, ovr_case && np > 1, par_case);
        check("R8", got_n, 1 + nd, "returned byte count");
        if (got_n > 0) begin
            check("R4", got_b[0][0], st[0], "status invalid bit");
            check("R5", got_b[0][1], st[1], "status missing-parameter bit");
            check("R6", got_b[0][2], st[2], "status overrun bit");
            check("R7", got_b[0][7:3], st[7:3], "status parity and upper bits");
        end
        for (int i = 0; i < nd && i + 1 < got_n; i++)
            check("R8", got_b[i+1], d[i], "reply byte");
        repeat (4) @(negedge clk);
        check("R9", {31'b0, we_line}, 1, "strobe released after reply");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] p [4];
        logic [7:0] d [4];
        void'($urandom(32'd20250));
        repeat (3) @(negedge clk);
        check("R1", {29'b0, dq_drive_low, we_drive_low, cmd_valid}, 0, "outputs in reset");
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R1", {29'b0, dq_drive_low, we_drive_low, cmd_valid}, 0, "outputs after reset");

        p = '{8'h11, 8'hA5, 8'h3C, 8'h00};
        d = '{8'h55, 8'hFF, 8'h00, 8'h81};
        run_txn(1'b0, 8'h00, 0, p, 0, d, 1'b0, 1'b0);  // empty transaction
        run_txn(1'b1, 8'h03, 2, p, 3, d, 1'b0, 1'b0);  // R3 parameters
        run_txn(1'b1, 8'h05, 0, p, 1, d, 1'b0, 1'b0);  // R5 missing parameter
        run_txn(1'b1, 8'h92, 2, p, 0, d, 1'b0, 1'b0);  // R2 clamp to 0x7F, R4 invalid
        run_txn(1'b1, 8'h08, 3, p, 2, d, 1'b0, 1'b0);  // R4 boundary code 8
        run_txn(1'b1, 8'h07, 1, p, 0, d, 1'b0, 1'b0);  // R4 boundary code 7 valid
        run_txn(1'b1, 8'h01, 2, p, 1, d, 1'b1, 1'b0);  // R6 overrun
        run_txn(1'b1, 8'h01, 1, p, 0, d, 1'b0, 1'b0);  // R6 overrun cleared
        run_txn(1'b1, 8'h02, 1, p, 2, d, 1'b0, 1'b1);  // R7 parity flag
        run_txn(1'b1, 8'h02, 0, p, 4, d, 1'b0, 1'b0);  // R7 cleared, full reply

        for (int t = 0; t < 16; t++) begin
            logic [7:0] c;
            int np, nd;
            c = 8'($urandom % 12);
            if ($urandom % 5 == 0) c = c | 8'h80;
            np = int'($urandom % 4);
            nd = int'($urandom % 4);
            for (int i = 0; i < 4; i++) begin
                p[i] = 8'($urandom);
                d[i] = 8'($urandom);
            end
            run_txn(1'b1, c, np, p, nd, d, 1'b0, ($urandom % 4) == 0);
        end

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule